// File: doc/BRIEF.md
# Rounding Saturating Fractional Multiplier

This block multiplies two signed fractional operands of `W` bits each. Each operand lies between -1 and 1 - 2^-(W-1). The block returns a `W`-bit fractional product in the same format. The double-width product is reduced to `W` bits using one of three rounding policies, chosen per operation: plain truncation, round-half-up, or round-to-nearest with ties to even. The rounded value is then saturated.

The only product that does not fit the fractional range is (-1)×(-1). The block clamps that case to the largest positive value instead of letting it wrap to -1, and raises an overflow flag alongside the result. Operands are accepted on a clock edge where `in_valid` is high. The result, the overflow flag and `out_valid` appear one cycle later. When no operation is presented, the output register keeps its last result.

Top module: `frac_mul_rs`

## Requirements
- R1: After reset, `out_valid`, `result` and `ovf` are all 0.
- R2: On a rising edge with `in_valid` high, the operands and mode are captured, and `out_valid` is high in the following cycle with the matching `result` and `ovf`.
- R3: With `round_mode` = 2'b00 (truncate), `result` is bits [2W-2:W-1] of the signed 2W-bit product. This is the floor of product / 2^(W-1).
- R4: With `round_mode` = 2'b01 (half-up), product bit W-2, the most significant discarded bit, is added as a carry into the truncated value.
- R5: With `round_mode` = 2'b10 (nearest-even), the discarded bits [W-2:0] are compared with one half. If they exceed 100…0, the result rounds up. If they are below it, the result is the truncated value. On an exact tie, the result rounds up only when the truncated value's LSB (product bit W-1) is 1.
- R6: `round_mode` = 2'b11 behaves exactly like truncation.
- R7: Operands 100…0 × 100…0 (i.e. -1 × -1) give `result` = 011…1 (largest positive value) and `ovf` = 1 in every rounding mode.
- R8: `ovf` is 0 for every other operand pair, in every mode.
- R9: A rising edge with `in_valid` low makes `out_valid` 0 in the next cycle and leaves `result` and `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | W | Multiplicand, signed fraction |
| op_b | input | W | Multiplier, signed fraction |
| round_mode | input | 2 | 00 truncate, 01 half-up, 10 nearest-even, 11 truncate |
| out_valid | output | 1 | Result registered from a valid operation |
| result | output | W | Rounded, saturated fractional product |
| ovf | output | 1 | Result was clamped |

## Verification
The hardest situations to reach are exact ties in nearest-even mode and the single overflowing operand pair. Random operands almost never produce a product whose W-1 discarded bits are exactly 100…0, and they hit 100…0 squared with a chance of 2^-2W.

The stimulus therefore builds ties on purpose. It multiplies a power-of-two operand at the discarded MSB position by small odd and even values, of both signs, so the truncated value arrives with each LSB parity. It also applies -1 × -1 in all four modes. After that, random traffic with random valid gaps covers ordinary rounding and the hold behaviour.

// File: rtl/frac_mul_rs_pkg.sv
// Package: shared types of the rounding saturating fractional multiplier.
// Assumes: the encoding below is the one driven on the top-level mode port.
package frac_mul_rs_pkg;

    // Rounding policy selector; the value 3 is an alias of truncation.
    typedef enum logic [1:0] {
        RND_TRUNC     = 2'b00,
        RND_HALF_UP   = 2'b01,
        RND_EVEN      = 2'b10,
        RND_TRUNC_ALT = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/frac_mul_rs_product.sv
// Module: full-precision signed product of two W-bit fractions.
// Assumes: operands are two's complement; the product is exact in 2W bits.
module frac_mul_rs_product #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   mul_a,
    input  logic signed [W-1:0]   mul_b,
    output logic signed [2*W-1:0] full_prod
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;

    // Purpose: sign-extend both operands to the product width.
    always_comb begin
        ext_a = PW'(mul_a);
        ext_b = PW'(mul_b);
    end

    // Purpose: exact double-width multiply (low half of extended product).
    assign full_prod = ext_a * ext_b;

endmodule

// File: rtl/frac_mul_rs_rounder.sv
// Module: reduces a 2W-bit fractional product to W+2 bits by rounding.
// Assumes: W >= 4; output is the kept part (product bits 2W-1..W-1,
// sign-extended by one bit) plus the increment of the selected policy.
module frac_mul_rs_rounder
    import frac_mul_rs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [2*W-1:0] full_prod,
    input  rnd_mode_e             mode,
    output logic signed [W+1:0]   rounded
);

    localparam int PW   = 2 * W;
    localparam int KW   = W + 2;     // kept width with headroom
    localparam int GPOS = W - 2;     // most significant discarded bit

    logic signed [KW-1:0] kept_ext;
    logic                 guard_bit;
    logic                 sticky_bit;
    logic                 kept_lsb;
    logic                 inc;

    // Purpose: kept part with one extra sign bit so +1 cannot wrap.
    assign kept_ext  = {full_prod[PW-1], full_prod[PW-1:W-1]};
    assign guard_bit = full_prod[GPOS];
    assign kept_lsb  = full_prod[W-1];

    // Purpose: OR of the discarded bits below the guard bit, if any exist.
    generate
        if (GPOS >= 1) begin : g_sticky
            assign sticky_bit = |full_prod[GPOS-1:0];
        end else begin : g_no_sticky
            assign sticky_bit = 1'b0;
        end
    endgenerate

    // Purpose: choose the rounding increment from the selected policy.
    always_comb begin
        case (mode)
            RND_HALF_UP: inc = guard_bit;
            RND_EVEN:    inc = guard_bit & (sticky_bit | kept_lsb);
            default:     inc = 1'b0;
        endcase
    end

    // Purpose: apply the increment to the kept part.
    assign rounded = kept_ext + {{(KW-1){1'b0}}, inc};

endmodule

// File: rtl/frac_mul_rs_saturate.sv
// Module: clamps a W+2 bit signed value into the W-bit fractional range.
// Assumes: input is the rounded product; out-of-range sets the flag.
module frac_mul_rs_saturate #(
    parameter int W = 16
) (
    input  logic signed [W+1:0] wide_val,
    output logic [W-1:0]        sat_val,
    output logic                sat_hit
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [2:0] top_bits;
    logic       fits;

    // Purpose: value fits when the three top bits are a pure sign extension.
    assign top_bits = wide_val[W+1:W-1];
    assign fits     = (&top_bits) | ~(|top_bits);

    // Purpose: pass through or clamp toward the sign of the wide value.
    always_comb begin
        sat_hit = ~fits;
        if (fits) begin
            sat_val = wide_val[W-1:0];
        end else if (wide_val[W+1]) begin
            sat_val = MAX_NEG;
        end else begin
            sat_val = MAX_POS;
        end
    end

endmodule

// File: rtl/frac_mul_rs.sv
// Module: top of the rounding saturating fractional multiplier.
// Does: product -> rounding (selected policy) -> saturation -> register.
// Assumes: W >= 4; synchronous active-low reset; one cycle latency;
// the output register holds its value when no operation is accepted.
module frac_mul_rs
    import frac_mul_rs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   round_mode,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         ovf
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] full_prod;
    logic signed [W+1:0]  rounded;
    logic [W-1:0]         sat_val;
    logic                 sat_hit;
    rnd_mode_e            mode_sel;

    // Purpose: map the raw mode pins onto the policy type.
    assign mode_sel = rnd_mode_e'(round_mode);

    frac_mul_rs_product #(.W(W)) product_i (
        .mul_a     (op_a),
        .mul_b     (op_b),
        .full_prod (full_prod)
    );

    frac_mul_rs_rounder #(.W(W)) rounder_i (
        .full_prod (full_prod),
        .mode      (mode_sel),
        .rounded   (rounded)
    );

    frac_mul_rs_saturate #(.W(W)) saturate_i (
        .wide_val (rounded),
        .sat_val  (sat_val),
        .sat_hit  (sat_hit)
    );

    // Purpose: output register; loads on a valid operation, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sat_val;
                ovf    <= sat_hit;
            end
        end
    end

endmodule

// File: rtl/frac_mul_rs_chk.sv
// Module: property checker for frac_mul_rs, attached by bind below.
// Assumes: observes top-level ports only.
module frac_mul_rs_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         ovf
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    // R2: an accepted operation yields out_valid one cycle later.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: no operation means no valid output next cycle.
    a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: result and flag hold across an idle edge.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(ovf)));

    // R7: minus one squared clamps to the largest positive value.
    a_r7_min_sq_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == MAX_NEG && op_b == MAX_NEG)
        |=> (ovf && result == MAX_POS));

    // R8: any other operand pair never flags overflow.
    a_r8_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(op_a == MAX_NEG && op_b == MAX_NEG)) |=> !ovf);

    // R7: a raised flag always comes with the clamped value.
    a_r7_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> result == MAX_POS);

endmodule

bind frac_mul_rs frac_mul_rs_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/frac_mul_rs_tb_top.sv
`timescale 1ns/1ps
module frac_mul_rs_tb_top;

    localparam int W = 16;
    localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (W-1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   round_mode = 2'b00;
    logic         out_valid;
    logic [W-1:0] result;
    logic         ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // expected outputs for the current cycle
    logic         exp_v = 1'b0;
    logic [W-1:0] exp_r = '0;
    logic         exp_o = 1'b0;
    string        exp_tag = "R1";

    always #2.5 clk = ~clk;

    frac_mul_rs #(.W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .round_mode (round_mode),
        .out_valid  (out_valid),
        .result     (result),
        .ovf        (ovf)
    );

    // behavioural reference: integer arithmetic, floor division, rules
    task automatic ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [1:0] m,
                             output logic [W-1:0] r, output logic o);
        longint p, kept, rem, half, v;
        p    = longint'($signed(a)) * longint'($signed(b));
        kept = p >>> (W-1);
        rem  = p - (kept <<< (W-1));
        half = 64'sd1 <<< (W-2);
        v    = kept;
        if (m == 2'b01 && rem >= half) v = kept + 1;
        if (m == 2'b10) begin
            if (rem > half) v = kept + 1;
            else if (rem == half && kept[0]) v = kept + 1;
        end
        o = 1'b0;
        if (v > MAXV) begin v = MAXV; o = 1'b1; end
        if (v < MINV) begin v = MINV; o = 1'b1; end
        r = v[W-1:0];
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic verify();
        check(out_valid == exp_v, exp_v ? "R2" : exp_tag, "out_valid",
              W'(out_valid), W'(exp_v));
        check(result == exp_r, exp_tag, "result", result, exp_r);
        check(ovf == exp_o, exp_o ? "R7" : (exp_v ? "R8" : exp_tag), "ovf",
              W'(ovf), W'(exp_o));
    endtask

    // one cycle: check outputs of the previous operation, drive the next
    task automatic step(input logic v, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [1:0] m,
                        input string tag);
        logic [W-1:0] r;
        logic         o;
        @(negedge clk);
        verify();
        in_valid   = v;
        op_a       = a;
        op_b       = b;
        round_mode = m;
        exp_v      = v;
        if (v) begin
            ref_model(a, b, m, r, o);
            exp_r   = r;
            exp_o   = o;
            exp_tag = tag;
        end else begin
            exp_tag = "R9";
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        logic [W-1:0] mn;
        logic [W-1:0] mx;
        mn = {1'b1, {(W-1){1'b0}}};
        mx = {1'b0, {(W-1){1'b1}}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: first step checks the reset state
        step(1'b0, '0, '0, 2'b00, "R1");
        // R7: minus one squared in every mode
        for (int m = 0; m < 4; m++) step(1'b1, mn, mn, 2'(m), "R7");
        // R9: idle after an overflow keeps the clamped value and flag
        step(1'b0, 16'h1234, 16'h4321, 2'b01, "R9");
        step(1'b0, mn, mn, 2'b00, "R9");
        // R5/R4/R3/R6: exact ties with both LSB parities and signs
        for (int m = 0; m < 4; m++) begin
            step(1'b1, 16'h0001, 16'h4000, 2'(m), mode_tag(2'(m)));
            step(1'b1, 16'h0003, 16'h4000, 2'(m), mode_tag(2'(m)));
            step(1'b1, 16'hFFFF, 16'h4000, 2'(m), mode_tag(2'(m)));
            step(1'b1, 16'hFFFD, 16'h4000, 2'(m), mode_tag(2'(m)));
            step(1'b1, 16'h0005, 16'h4001, 2'(m), mode_tag(2'(m)));
            step(1'b1, 16'h0005, 16'h3FFF, 2'(m), mode_tag(2'(m)));
            step(1'b1, mx, mx, 2'(m), mode_tag(2'(m)));
            step(1'b1, mn, mx, 2'(m), "R8");
            step(1'b1, 16'h0000, mn, 2'(m), "R8");
        end
        // random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] m;
            logic       v;
            m = 2'($urandom_range(0, 3));
            v = ($urandom_range(0, 3) != 0);
            step(v, W'($urandom), W'($urandom), m, mode_tag(m));
        end
        step(1'b0, '0, '0, 2'b00, "R9");
        step(1'b0, '0, '0, 2'b00, "R9");
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule